// File: doc/BRIEF.md
# Fetch Queue with Static Prediction

The block is a three-slot instruction queue between the instruction cache and the decode stage. Going from oldest to youngest, the slots are a decode slot and two prefetch slots, PF0 and PF1. Each cycle the block presents a fetch address. When it raises its request, the cache can return up to two consecutive instructions at that address in the same cycle. If the queue is empty, the first returned instruction goes straight into the decode slot. It does not pass through the prefetch slots.

The block looks at two slots in every cycle: the decode slot and PF0. For each, a static rule predicts whether the branch there is taken. The rule uses the instruction's branch fields, which are the branch flag, whether the branch tests the condition or count register, a software hint bit and the sign of the displacement. A taken prediction in decode redirects fetch to that branch's target and discards everything younger. If decode holds no taken prediction, a taken prediction in PF0 does the same for the slots behind it. A flush input, which comes from branch resolution further down the pipe, empties the queue and loads a redirect address.

Top module: `fetch_pred_queue`

## Requirements
- R1: After reset, dec_valid_o is 0, fetch_addr_o equals RESET_ADDR and fetch_req_o is 1.
- R2: A cycle can accept two instructions. Word 0 is in fill_data_i[31:0] at fetch_addr_o, and word 1 is in fill_data_i[63:32] at fetch_addr_o+4. Word 1 counts only when word 0 is valid. fetch_addr_o advances by 4 for each accepted instruction.
- R3: When the queue is empty, an accepted word 0 is shown at the decode outputs in the next cycle.
- R4: Instructions leave the decode slot in the order they were accepted. The slot advances in each cycle where dec_ready_i is 1.
- R5: fetch_req_o is 0 when fewer than two slots would be free after this cycle's decode advance. In such a cycle fill data is ignored and fetch_addr_o holds.
- R6: Instruction encoding: bit 31 marks a branch, bit 30 set means the branch tests the condition or count register, bit 29 is the hint, and bits 15:0 hold a signed byte displacement. A branch with bit 30 clear is predicted taken. A branch with bit 30 set is predicted taken exactly when (displacement < 0) XOR hint. A non-branch is never predicted taken.
- R7: The target of a predicted-taken branch is its own address plus the sign-extended displacement.
- R8: If the decode slot holds a predicted-taken branch, fetch_addr_o becomes its target in the next cycle. PF0, PF1 and that cycle's fill are discarded.
- R9: If decode holds no predicted-taken branch and PF0 does, fetch_addr_o becomes PF0's target in the next cycle. PF1 and that cycle's fill are discarded, and PF0 is kept.
- R10: A branch redirects fetch only once, even while it waits in the queue.
- R11: flush_i empties the queue, ignores that cycle's fill, and sets fetch_addr_o to redirect_addr_i in the next cycle.
- R12: dec_pred_taken_o gives the R6 prediction for the instruction in the decode slot, and is 0 when the slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Resolved redirect: empty the queue |
| redirect_addr_i | input | ADDR_W | Fetch address used on flush |
| fetch_req_o | output | 1 | Queue has room for a two-word fill |
| fetch_addr_o | output | ADDR_W | Current fetch address |
| fill_vld_i | input | 2 | Valid flags of the two returned words |
| fill_data_i | input | 2*INSTR_W | Returned words, word 0 in the low half |
| dec_ready_i | input | 1 | Decode consumes its slot this cycle |
| dec_valid_o | output | 1 | Decode slot holds an instruction |
| dec_instr_o | output | INSTR_W | Instruction in the decode slot |
| dec_pc_o | output | ADDR_W | Address of that instruction |
| dec_pred_taken_o | output | 1 | Static prediction for that instruction |

## Verification
The bench builds the block with its default widths: a 32-bit address, 32-bit instructions and a 16-bit displacement. RESET_ADDR is set to 0x100 so that the reset value cannot be mistaken for a zero default. Running from bases around 0x1000 puts negative displacements within reach. Those displacements produce targets below the base, which exposes a missing sign extension in the target adder as well as a wrong sign test in the prediction rule. Keeping two words per fill with three slots lets a single stalled decode reach the full stall condition. The same setup lets a taken branch land in decode and in PF0 while another branch sits right behind it.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned FILL_W    = 2;
  localparam int unsigned EXAM_W    = 2;  // slots examined for branches
  localparam int unsigned SLOT_DCD  = 0;
  localparam int unsigned SLOT_PF0  = 1;

  typedef enum logic [1:0] {
    REDIR_NONE,
    REDIR_FLUSH,
    REDIR_DCD,
    REDIR_PF0
  } redir_e;
endpackage

// File: rtl/fq_predict.sv
module fq_predict #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 16
) (
  input  logic [IW-1:0] instr_i,
  input  logic [AW-1:0] pc_i,
  output logic          pred_o,
  output logic [AW-1:0] target_o
);
  logic is_br, uses_cr, hint, neg;

  assign is_br   = instr_i[IW-1];
  assign uses_cr = instr_i[IW-2];
  assign hint    = instr_i[IW-3];
  assign neg     = instr_i[DW-1];

  // unconditional: always taken; conditional: backward taken, hint flips
  assign pred_o   = is_br & (~uses_cr | (neg ^ hint));
  assign target_o = pc_i + {{(AW-DW){instr_i[DW-1]}}, instr_i[DW-1:0]};
endmodule

// File: rtl/fq_store.sv
module fq_store #(
  parameter int unsigned AW   = 32,
  parameter int unsigned IW   = 32,
  parameter int unsigned NS   = 3,
  parameter int unsigned FW   = 2,
  parameter int unsigned STEP = 4,
  localparam int unsigned CW  = $clog2(NS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   kill_dcd_i,
  input  logic                   kill_pf0_i,
  input  logic                   pop_i,
  input  logic [FW-1:0]          push_i,
  input  logic [FW-1:0][IW-1:0]  push_ins_i,
  input  logic [AW-1:0]          push_pc_i,
  output logic [NS-1:0]          vld_o,
  output logic [NS-1:0]          done_o,
  output logic [NS-1:0][IW-1:0]  ins_o,
  output logic [NS-1:0][AW-1:0]  pc_o,
  output logic [CW-1:0]          cnt_o
);
  logic [NS-1:0]         vld_q, vld_n, done_q, done_n;
  logic [NS-1:0][IW-1:0] ins_q, ins_n;
  logic [NS-1:0][AW-1:0] pc_q, pc_n;
  int                    fill;

  always_comb begin
    vld_n  = vld_q;
    done_n = done_q;
    ins_n  = ins_q;
    pc_n   = pc_q;
    if (flush_i) begin
      vld_n = '0;
    end else if (kill_dcd_i) begin
      done_n[0]      = 1'b1;
      vld_n[NS-1:1]  = '0;
    end else if (kill_pf0_i) begin
      done_n[1]      = 1'b1;
      vld_n[NS-1:2]  = '0;
    end
    if (pop_i && vld_n[0]) begin
      for (int k = 0; k < NS - 1; k++) begin
        vld_n[k]  = vld_n[k+1];
        done_n[k] = done_n[k+1];
        ins_n[k]  = ins_n[k+1];
        pc_n[k]   = pc_n[k+1];
      end
      vld_n[NS-1] = 1'b0;
    end
    fill = 0;
    for (int k = 0; k < NS; k++) fill += int'(vld_n[k]);
    for (int f = 0; f < FW; f++) begin
      for (int k = 0; k < NS; k++) begin
        if (push_i[f] && k == fill + f) begin
          vld_n[k]  = 1'b1;
          done_n[k] = 1'b0;
          ins_n[k]  = push_ins_i[f];
          pc_n[k]   = push_pc_i + AW'(f) * AW'(STEP);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      done_q <= '0;
      ins_q  <= '0;
      pc_q   <= '0;
    end else begin
      vld_q  <= vld_n;
      done_q <= done_n;
      ins_q  <= ins_n;
      pc_q   <= pc_n;
    end
  end

  assign vld_o  = vld_q;
  assign done_o = done_q;
  assign ins_o  = ins_q;
  assign pc_o   = pc_q;
  assign cnt_o  = CW'($countones(vld_q));
endmodule

// File: rtl/fq_fetch_addr.sv
module fq_fetch_addr
  import fq_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter int unsigned    NW         = 2,
  parameter int unsigned    STEP       = 4,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  redir_e        sel_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic [AW-1:0] dcd_tgt_i,
  input  logic [AW-1:0] pf0_tgt_i,
  input  logic [NW-1:0] n_push_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    unique case (sel_i)
      REDIR_FLUSH: addr_n = flush_addr_i;
      REDIR_DCD:   addr_n = dcd_tgt_i;
      REDIR_PF0:   addr_n = pf0_tgt_i;
      default:     addr_n = addr_q + AW'(n_push_i) * AW'(STEP);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= RESET_ADDR;
    else         addr_q <= addr_n;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/fetch_pred_queue.sv
module fetch_pred_queue
  import fq_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        INSTR_W    = 32,
  parameter int unsigned        DISP_W     = 16,
  parameter logic [ADDR_W-1:0]  RESET_ADDR = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic [ADDR_W-1:0]           redirect_addr_i,
  output logic                        fetch_req_o,
  output logic [ADDR_W-1:0]           fetch_addr_o,
  input  logic [FILL_W-1:0]           fill_vld_i,
  input  logic [FILL_W*INSTR_W-1:0]   fill_data_i,
  input  logic                        dec_ready_i,
  output logic                        dec_valid_o,
  output logic [INSTR_W-1:0]          dec_instr_o,
  output logic [ADDR_W-1:0]           dec_pc_o,
  output logic                        dec_pred_taken_o
);
  localparam int unsigned STEP = INSTR_W / 8;
  localparam int unsigned CW   = $clog2(NUM_SLOTS + 1);
  localparam int unsigned NW   = $clog2(FILL_W + 1);

  logic [NUM_SLOTS-1:0]              slot_vld, slot_done;
  logic [NUM_SLOTS-1:0][INSTR_W-1:0] slot_ins;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_pc;
  logic [CW-1:0]                     cnt, occ_after;
  logic [EXAM_W-1:0]                 pred;
  logic [EXAM_W-1:0][ADDR_W-1:0]     tgt;
  logic                              pop, kill_dcd, kill_pf0, accept;
  logic [FILL_W-1:0]                 push;
  logic [NW-1:0]                     n_push;
  redir_e                            sel;

  for (genvar g = 0; g < EXAM_W; g++) begin : g_pred
    fq_predict #(.AW(ADDR_W), .IW(INSTR_W), .DW(DISP_W)) u_pred (
      .instr_i  (slot_ins[g]),
      .pc_i     (slot_pc[g]),
      .pred_o   (pred[g]),
      .target_o (tgt[g])
    );
  end

  assign kill_dcd = slot_vld[SLOT_DCD] & ~slot_done[SLOT_DCD] & pred[SLOT_DCD];
  assign kill_pf0 = ~kill_dcd & slot_vld[SLOT_PF0] & ~slot_done[SLOT_PF0] & pred[SLOT_PF0];

  assign pop         = dec_ready_i & slot_vld[SLOT_DCD];
  assign occ_after   = cnt - CW'(pop);
  assign fetch_req_o = occ_after <= CW'(NUM_SLOTS - FILL_W);
  assign accept      = fetch_req_o & ~flush_i & ~kill_dcd & ~kill_pf0;

  for (genvar f = 0; f < FILL_W; f++) begin : g_push
    assign push[f] = accept & (&fill_vld_i[f:0]);
  end
  assign n_push = NW'($countones(push));

  always_comb begin
    if (flush_i)       sel = REDIR_FLUSH;
    else if (kill_dcd) sel = REDIR_DCD;
    else if (kill_pf0) sel = REDIR_PF0;
    else               sel = REDIR_NONE;
  end

  fq_store #(
    .AW(ADDR_W), .IW(INSTR_W), .NS(NUM_SLOTS), .FW(FILL_W), .STEP(STEP)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .kill_dcd_i (kill_dcd),
    .kill_pf0_i (kill_pf0),
    .pop_i      (pop),
    .push_i     (push),
    .push_ins_i (fill_data_i),
    .push_pc_i  (fetch_addr_o),
    .vld_o      (slot_vld),
    .done_o     (slot_done),
    .ins_o      (slot_ins),
    .pc_o       (slot_pc),
    .cnt_o      (cnt)
  );

  fq_fetch_addr #(
    .AW(ADDR_W), .NW(NW), .STEP(STEP), .RESET_ADDR(RESET_ADDR)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel),
    .flush_addr_i (redirect_addr_i),
    .dcd_tgt_i    (tgt[SLOT_DCD]),
    .pf0_tgt_i    (tgt[SLOT_PF0]),
    .n_push_i     (n_push),
    .addr_o       (fetch_addr_o)
  );

  assign dec_valid_o      = slot_vld[SLOT_DCD];
  assign dec_instr_o      = slot_ins[SLOT_DCD];
  assign dec_pc_o         = slot_pc[SLOT_DCD];
  assign dec_pred_taken_o = slot_vld[SLOT_DCD] & pred[SLOT_DCD];
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned DISP_W  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic [ADDR_W-1:0]      redirect_addr_i,
  input logic                   fetch_req_o,
  input logic [ADDR_W-1:0]      fetch_addr_o,
  input logic [2*INSTR_W-1:0]   fill_data_i,
  input logic                   dec_ready_i,
  input logic                   dec_valid_o,
  input logic [INSTR_W-1:0]     dec_instr_o,
  input logic [ADDR_W-1:0]      dec_pc_o,
  input logic                   dec_pred_taken_o,
  input logic                   kill_dcd_i,
  input logic                   kill_pf0_i,
  input logic [1:0]             push_i
);
  localparam int unsigned STEP = INSTR_W / 8;

  logic [ADDR_W-1:0] dec_tgt;
  assign dec_tgt = dec_pc_o + {{(ADDR_W-DISP_W){dec_instr_o[DISP_W-1]}}, dec_instr_o[DISP_W-1:0]};

  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dec_valid_o && fetch_addr_o == $past(redirect_addr_i));

  a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o && push_i[0] |=> dec_valid_o && dec_instr_o == $past(fill_data_i[INSTR_W-1:0]));

  a_r2_two_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i[1] |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2 * STEP));

  a_r5_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_o && !flush_i && !kill_dcd_i && !kill_pf0_i |=> $stable(fetch_addr_o));

  a_r5_stall_needs_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_o |-> dec_valid_o);

  a_r8_dcd_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_dcd_i && !flush_i |=> fetch_addr_o == $past(dec_tgt));

  a_r8_dcd_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_dcd_i && !flush_i && !dec_ready_i |=> dec_valid_o && $stable(dec_instr_o));

  a_r10_dcd_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_dcd_i |=> !kill_dcd_i);

  a_r10_pf0_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_pf0_i |=> !kill_pf0_i);

  a_r12_pred_branch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_pred_taken_o |-> dec_valid_o && dec_instr_o[INSTR_W-1]);
endmodule

bind fetch_pred_queue fq_checker #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .DISP_W(DISP_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .flush_i          (flush_i),
  .redirect_addr_i  (redirect_addr_i),
  .fetch_req_o      (fetch_req_o),
  .fetch_addr_o     (fetch_addr_o),
  .fill_data_i      (fill_data_i),
  .dec_ready_i      (dec_ready_i),
  .dec_valid_o      (dec_valid_o),
  .dec_instr_o      (dec_instr_o),
  .dec_pc_o         (dec_pc_o),
  .dec_pred_taken_o (dec_pred_taken_o),
  .kill_dcd_i       (kill_dcd),
  .kill_pf0_i       (kill_pf0),
  .push_i           (push)
);

// File: tb/sim_fetch_pred_queue.sv
`timescale 1ns/1ps
module sim_fetch_pred_queue;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] redir = '0;
  logic        req;
  logic [31:0] faddr;
  logic [1:0]  fvld = '0;
  logic [63:0] fdata = '0;
  logic        drdy = 1'b0;
  logic        dvld;
  logic [31:0] dins, dpc;
  logic        dpred;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fetch_pred_queue #(
    .ADDR_W(32), .INSTR_W(32), .DISP_W(16), .RESET_ADDR(32'h100)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .redirect_addr_i(redir),
    .fetch_req_o(req), .fetch_addr_o(faddr), .fill_vld_i(fvld), .fill_data_i(fdata),
    .dec_ready_i(drdy), .dec_valid_o(dvld), .dec_instr_o(dins), .dec_pc_o(dpc),
    .dec_pred_taken_o(dpred)
  );

  // {instr, expected prediction, expected fetch address after decode cycle}, base 0x1000
  localparam logic [64:0] VEC [8] = '{
    {32'h0000_0010, 1'b0, 32'h0000_1004},  // non-branch
    {32'h8000_0040, 1'b1, 32'h0000_1040},  // unconditional forward
    {32'h8000_FFE0, 1'b1, 32'h0000_0FE0},  // unconditional backward
    {32'hC000_0040, 1'b0, 32'h0000_1004},  // conditional forward
    {32'hC000_FFF0, 1'b1, 32'h0000_0FF0},  // conditional backward
    {32'hE000_0040, 1'b1, 32'h0000_1040},  // forward, hint set
    {32'hE000_FFF0, 1'b0, 32'h0000_1004},  // backward, hint set
    {32'hA000_0100, 1'b1, 32'h0000_1100}   // unconditional, hint ignored
  };

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_flush(input logic [31:0] a);
    flush = 1'b1;
    redir = a;
    step();
    flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    chk("R1 dec_valid", 32'(dvld), 32'd0);
    chk("R1 fetch_addr", faddr, 32'h100);
    chk("R1 fetch_req", 32'(req), 32'd1);

    // table of prediction cases
    for (int v = 0; v < 8; v++) begin
      do_flush(32'h1000);
      fvld  = 2'b01;
      fdata = {32'h0, VEC[v][64:33]};
      step();
      fvld = 2'b00;
      chk("R6 R12 prediction", 32'(dpred), 32'(VEC[v][32]));
      step();
      chk("R7 next fetch addr", faddr, VEC[v][31:0]);
    end

    // two per cycle, bypass, order
    do_flush(32'h2000);
    fvld = 2'b11; fdata = {32'h22, 32'h11};
    step();
    fvld = 2'b00;
    chk("R2 addr +8", faddr, 32'h2008);
    chk("R3 bypass valid", 32'(dvld), 32'd1);
    chk("R3 bypass instr", dins, 32'h11);
    drdy = 1'b1;
    step();
    chk("R4 second instr", dins, 32'h22);
    step();
    chk("R4 drained", 32'(dvld), 32'd0);
    drdy = 1'b0;

    // stall
    do_flush(32'h3000);
    fvld = 2'b11; fdata = {32'h22, 32'h11};
    step();
    #1;
    chk("R5 req low", 32'(req), 32'd0);
    fdata = {32'h44, 32'h33};
    step();
    fvld = 2'b00;
    chk("R5 addr held", faddr, 32'h3008);
    drdy = 1'b1;
    #1;
    chk("R5 req with pop", 32'(req), 32'd1);
    step();
    chk("R5 next instr", dins, 32'h22);
    step();
    chk("R5 stalled fill ignored", 32'(dvld), 32'd0);
    drdy = 1'b0;

    // taken branch in decode, branch behind it
    do_flush(32'h4000);
    fvld = 2'b11; fdata = {32'h8000_0200, 32'h8000_0100};
    step();
    fvld = 2'b00;
    step();
    chk("R8 redirect addr", faddr, 32'h4100);
    chk("R8 decode kept", dins, 32'h8000_0100);
    step();
    chk("R10 no repeat", faddr, 32'h4100);
    drdy = 1'b1;
    step();
    chk("R8 pf0 discarded", 32'(dvld), 32'd0);
    drdy = 1'b0;

    // not-taken in decode, taken in PF0, fill dropped
    do_flush(32'h5000);
    fvld = 2'b11; fdata = {32'h8000_0080, 32'hC000_0040};
    step();
    drdy = 1'b1;
    fdata = {32'h44, 32'h33};
    step();
    fvld = 2'b00;
    chk("R9 redirect addr", faddr, 32'h5084);
    chk("R9 pf0 kept", dins, 32'h8000_0080);
    chk("R12 pred of pf0 branch", 32'(dpred), 32'd1);
    step();
    chk("R9 fill discarded", 32'(dvld), 32'd0);
    chk("R10 no second redirect", faddr, 32'h5084);
    drdy = 1'b0;

    // flush with concurrent fill
    do_flush(32'h6000);
    fvld = 2'b11; fdata = {32'h22, 32'h11};
    step();
    flush = 1'b1; redir = 32'h7000;
    step();
    flush = 1'b0; fvld = 2'b00;
    chk("R11 cleared", 32'(dvld), 32'd0);
    chk("R11 redirect", faddr, 32'h7000);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule